// File: doc/BRIEF.md
# Two-Phase Peripheral Bus Requester

This block turns single commands from a local client into transfers on a simple peripheral bus with no wait states. A client presents an address, a direction flag, write data and the index of the target peripheral, and hands them over with a valid/ready handshake. The requester then drives the bus for exactly two clock cycles. In the first cycle it asserts the select line of the chosen peripheral and keeps the enable strobe low. In the second cycle it raises the enable strobe. The bus has no response signal, so the block never waits on the peripheral.

For a read, the word on the read data bus is sampled at the rising edge that closes the second cycle. It is returned on the response port together with a one-cycle completion pulse. A write also produces the completion pulse, and the returned read word keeps its previous value. If the client offers another command while the enable cycle is running, that command is taken at once and its first cycle follows immediately. Without one, the select line drops and the bus goes idle.

Top module: `pbus_req_master`

## Requirements
- R1: Every transfer is one setup cycle (select high, enable low) followed by exactly one access cycle (select high, enable high). The access cycle never lasts more than one cycle, and the block has no ready or response input from the bus.
- R2: During a transfer `bus_sel` is one-hot with bit `cmd_slave` set. When no transfer is running, `bus_sel` is all zeros.
- R3: `bus_enable` is high only in the second cycle of a transfer, and only directly after a setup cycle.
- R4: `bus_write` is 1 for a write command (`cmd_write`=1) and 0 for a read command.
- R5: `bus_addr`, `bus_write`, `bus_wdata` and `bus_sel` keep the same value through both cycles of a transfer. Command inputs that change while a transfer runs have no effect on them.
- R6: A command is taken at a rising edge where `cmd_valid` and `cmd_ready` are both high, and its setup cycle is the next cycle. `cmd_ready` is low during a setup cycle and high in idle and access cycles. A command offered during setup is not taken and does not alter the bus.
- R7: For a read, `bus_rdata` is sampled at the edge that ends the access cycle and appears on `rsp_rdata`. `rsp_valid` is high for exactly the one cycle after every access cycle. After a write, `rsp_rdata` keeps the word of the previous read.
- R8: A command taken at the end of an access cycle starts its setup cycle with no idle cycle between the two transfers. Otherwise `bus_sel` falls to zero after the access cycle.
- R9: While `rst_n` is low, `bus_sel`, `bus_enable`, `rsp_valid`, `rsp_rdata` and `cmd_ready` are all 0, and assertion takes effect without a clock edge, even in the middle of a transfer. After `rst_n` rises, `cmd_ready` goes high at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all timing on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | ADDR_W (32) | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W (32) | Write data |
| cmd_slave | input | SLV_W (2) | Index of the target peripheral |
| bus_sel | output | N_SLAVES (4) | One select line per peripheral |
| bus_enable | output | 1 | Strobe for the second transfer cycle |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | ADDR_W (32) | Bus address |
| bus_wdata | output | DATA_W (32) | Bus write data |
| bus_rdata | input | DATA_W (32) | Bus read data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (32) | Last read word |

## Verification
The bench targets back-to-back commands. A requester that inserts an idle cycle, or that lets the enable strobe run into the next setup cycle, fails the select and enable checks in the cycle after the first access. The bench offers a second command during setup with different fields. A design that loads command registers without regard to the handshake changes the bus address during the transfer. It also checks that `bus_rdata` changing after the sampling edge, and a write following a read, leave the returned word alone: sampling one edge late or capturing on writes returns the wrong value. Finally, the bench pulls reset low in the middle of a setup cycle and expects the select to drop before any clock edge. A synchronously cleared design leaves it high.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pbus_seq_fsm.sv
module pbus_seq_fsm
  import pbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  output logic load_cmd,
  output logic in_setup,
  output logic in_access
);

  xfer_state_e state_q;
  xfer_state_e state_d;

  assign cmd_ready = rst_n && (state_q != ST_SETUP);
  assign load_cmd  = cmd_valid && cmd_ready;
  assign in_setup  = (state_q == ST_SETUP);
  assign in_access = (state_q == ST_ACCESS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load_cmd) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: state_d = load_cmd ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> in_access); // R1
  AST_NO_TAKE_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |-> !load_cmd); // R6

endmodule

// File: rtl/pbus_cmd_regs.sv
module pbus_cmd_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SLV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [SLV_W-1:0]  cmd_slave,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [SLV_W-1:0]  slave_q
);

  logic [ADDR_W-1:0] addr_d;
  logic              write_d;
  logic [DATA_W-1:0] wdata_d;
  logic [SLV_W-1:0]  slave_d;

  always_comb begin
    addr_d  = addr_q;
    write_d = write_q;
    wdata_d = wdata_q;
    slave_d = slave_q;
    if (load_cmd) begin
      addr_d  = cmd_addr;
      write_d = cmd_write;
      wdata_d = cmd_wdata;
      slave_d = cmd_slave;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      slave_q <= '0;
    end else begin
      addr_q  <= addr_d;
      write_q <= write_d;
      wdata_q <= wdata_d;
      slave_q <= slave_d;
    end
  end

endmodule

// File: rtl/pbus_sel_decode.sv
module pbus_sel_decode #(
  parameter int N_SLAVES = 4,
  parameter int SLV_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [SLV_W-1:0]    slave_idx,
  output logic [N_SLAVES-1:0] sel
);

  for (genvar g = 0; g < N_SLAVES; g++) begin : g_sel
    assign sel[g] = active && (slave_idx == SLV_W'(g));
  end

  AST_SEL_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2

endmodule

// File: rtl/pbus_rsp_capture.sv
module pbus_rsp_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_access,
  input  logic              write_q,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic              done_d;
  logic              take_rd;
  logic [DATA_W-1:0] rdata_d;

  assign take_rd = in_access && !write_q;

  always_comb begin
    done_d  = in_access;
    rdata_d = rsp_rdata;
    if (take_rd) begin
      rdata_d = bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done_d;
      rsp_rdata <= rdata_d;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

endmodule

// File: rtl/pbus_req_master.sv
module pbus_req_master #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_SLAVES = 4,
  localparam int SLV_W   = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                cmd_write,
  input  logic [DATA_W-1:0]   cmd_wdata,
  input  logic [SLV_W-1:0]    cmd_slave,
  output logic [N_SLAVES-1:0] bus_sel,
  output logic                bus_enable,
  output logic                bus_write,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);

  logic             rst_sync_n;
  logic             load_cmd;
  logic             in_setup;
  logic             in_access;
  logic [SLV_W-1:0] slave_q;

  pbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbus_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .load_cmd  (load_cmd),
    .in_setup  (in_setup),
    .in_access (in_access)
  );

  pbus_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLV_W(SLV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_cmd  (load_cmd),
    .cmd_addr  (cmd_addr),
    .cmd_write (cmd_write),
    .cmd_wdata (cmd_wdata),
    .cmd_slave (cmd_slave),
    .addr_q    (bus_addr),
    .write_q   (bus_write),
    .wdata_q   (bus_wdata),
    .slave_q   (slave_q)
  );

  pbus_sel_decode #(.N_SLAVES(N_SLAVES), .SLV_W(SLV_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (in_setup || in_access),
    .slave_idx (slave_q),
    .sel       (bus_sel)
  );

  pbus_rsp_capture #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_access (in_access),
    .write_q   (bus_write),
    .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign bus_enable = in_access;

  AST_ENABLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_enable |=> !bus_enable); // R1
  AST_ENABLE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_enable |-> ($past(|bus_sel) && !$past(bus_enable))); // R3
  AST_SEL_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_enable |-> (|bus_sel)); // R2
  AST_ACCESS_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_enable |-> ($stable(bus_sel) && $stable(bus_addr) &&
                    $stable(bus_write) && $stable(bus_wdata))); // R5
  AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $past(bus_enable)); // R7
  AST_READY_NOT_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|bus_sel) && !bus_enable) |-> !cmd_ready); // R6

endmodule

// File: tb/pbus_req_master_tb.sv
module pbus_req_master_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NS = 4;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic          cmd_write;
  logic [DW-1:0] cmd_wdata;
  logic [1:0]    cmd_slave;
  logic [NS-1:0] bus_sel;
  logic          bus_enable;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int            n_checks;
  int            n_err;
  logic [DW-1:0] last_rd;

  pbus_req_master #(.ADDR_W(AW), .DATA_W(DW), .N_SLAVES(NS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_write  (cmd_write),
    .cmd_wdata  (cmd_wdata),
    .cmd_slave  (cmd_slave),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] onehot(input logic [1:0] idx);
    return NS'(1) << idx;
  endfunction

  task automatic offer(input logic [AW-1:0] a, input logic w,
                       input logic [DW-1:0] d, input logic [1:0] s);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    cmd_write = w;
    cmd_wdata = d;
    cmd_slave = s;
  endtask

  // One isolated transfer from idle; checks every cycle of it.
  task automatic t_single(input logic [AW-1:0] a, input logic w,
                          input logic [DW-1:0] d, input logic [1:0] s,
                          input logic [DW-1:0] rd);
    logic [DW-1:0] exp_rsp;
    @(negedge clk);
    offer(a, w, d, s);
    chk(cmd_ready == 1'b1, "R6", "ready in idle", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr  = ~a;
    cmd_wdata = ~d;
    cmd_write = ~w;
    bus_rdata = ~rd;
    chk(bus_sel == onehot(s), "R2", "setup select", 64'(bus_sel), 64'(onehot(s)));
    chk(bus_enable == 1'b0, "R1", "setup enable", 64'(bus_enable), 64'd0);
    chk(bus_write == w, "R4", "direction", 64'(bus_write), 64'(w));
    chk(bus_addr == a, "R5", "setup address", 64'(bus_addr), 64'(a));
    chk(cmd_ready == 1'b0, "R6", "ready in setup", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    bus_rdata = rd;
    chk(bus_enable == 1'b1, "R3", "access enable", 64'(bus_enable), 64'd1);
    chk(bus_sel == onehot(s), "R5", "access select", 64'(bus_sel), 64'(onehot(s)));
    chk(bus_addr == a && bus_wdata == d && bus_write == w, "R5", "access fields held",
        64'(bus_addr), 64'(a));
    @(negedge clk);
    bus_rdata = ~rd;
    exp_rsp = w ? last_rd : rd;
    if (!w) last_rd = rd;
    chk(rsp_valid == 1'b1, "R7", "completion pulse", 64'(rsp_valid), 64'd1);
    chk(rsp_rdata == exp_rsp, "R7", "returned word", 64'(rsp_rdata), 64'(exp_rsp));
    chk(bus_sel == '0 && bus_enable == 1'b0, "R8", "bus idle after access",
        64'(bus_sel), 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "pulse ends", 64'(rsp_valid), 64'd0);
    chk(rsp_rdata == exp_rsp, "R7", "word held", 64'(rsp_rdata), 64'(exp_rsp));
  endtask

  // Read on slave sa, write on slave sb offered during setup and taken in access.
  task automatic t_back_to_back();
    @(negedge clk);
    offer(32'h0000_1100, 1'b0, 32'h0, 2'd1);
    @(negedge clk);
    offer(32'h0000_2200, 1'b1, 32'hCAFE_F00D, 2'd2);
    chk(bus_addr == 32'h0000_1100, "R6", "offer in setup ignored", 64'(bus_addr), 64'h1100);
    chk(bus_sel == onehot(2'd1), "R6", "select unchanged in setup", 64'(bus_sel),
        64'(onehot(2'd1)));
    @(negedge clk);
    bus_rdata = 32'h5151_A0A0;
    chk(cmd_ready == 1'b1, "R6", "ready in access", 64'(cmd_ready), 64'd1);
    chk(bus_addr == 32'h0000_1100 && bus_write == 1'b0, "R5", "first access held",
        64'(bus_addr), 64'h1100);
    @(negedge clk);
    cmd_valid = 1'b0;
    bus_rdata = 32'h0;
    last_rd   = 32'h5151_A0A0;
    chk(bus_sel == onehot(2'd2), "R8", "second setup without gap", 64'(bus_sel),
        64'(onehot(2'd2)));
    chk(bus_enable == 1'b0, "R8", "enable low in second setup", 64'(bus_enable), 64'd0);
    chk(bus_addr == 32'h0000_2200 && bus_write == 1'b1, "R4", "second command fields",
        64'(bus_addr), 64'h2200);
    chk(rsp_valid == 1'b1 && rsp_rdata == 32'h5151_A0A0, "R7", "first read returned",
        64'(rsp_rdata), 64'h5151_A0A0);
    @(negedge clk);
    chk(bus_enable == 1'b1 && bus_wdata == 32'hCAFE_F00D, "R3", "second access",
        64'(bus_wdata), 64'hCAFE_F00D);
    chk(rsp_valid == 1'b0, "R7", "no pulse during second access", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_rdata == 32'h5151_A0A0, "R7", "write keeps read word",
        64'(rsp_rdata), 64'h5151_A0A0);
    chk(bus_sel == '0, "R8", "select drops", 64'(bus_sel), 64'd0);
  endtask

  task automatic t_idle_quiet();
    cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_sel == '0 && bus_enable == 1'b0, "R2", "quiet bus while idle",
          64'(bus_sel), 64'd0);
    end
  endtask

  task automatic t_reset_mid_transfer();
    @(negedge clk);
    offer(32'h0000_3300, 1'b0, 32'h0, 2'd3);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_sel == onehot(2'd3), "R2", "setup before reset", 64'(bus_sel),
        64'(onehot(2'd3)));
    #1 rst_n = 1'b0;
    #1;
    chk(bus_sel == '0 && bus_enable == 1'b0, "R9", "async clear of select",
        64'(bus_sel), 64'd0);
    chk(rsp_rdata == '0 && cmd_ready == 1'b0, "R9", "async clear of response",
        64'(rsp_rdata), 64'd0);
    last_rd = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R9", "ready after one edge", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready after two edges", 64'(cmd_ready), 64'd1);
  endtask

  initial begin
    n_checks  = 0;
    n_err     = 0;
    last_rd   = '0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_addr  = '0;
    cmd_write = 1'b0;
    cmd_wdata = '0;
    cmd_slave = '0;
    bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk(bus_sel == '0 && bus_enable == 1'b0, "R9", "bus idle in reset", 64'(bus_sel), 64'd0);
    chk(rsp_valid == 1'b0 && rsp_rdata == '0, "R9", "response clear in reset",
        64'(rsp_rdata), 64'd0);
    chk(cmd_ready == 1'b0, "R9", "no ready in reset", 64'(cmd_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R9", "ready after one edge", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready after two edges", 64'(cmd_ready), 64'd1);

    t_single(32'h4000_0010, 1'b0, 32'h0, 2'd0, 32'hDEAD_BEEF);
    t_single(32'h4000_0024, 1'b1, 32'h1234_5678, 2'd3, 32'h0BAD_0BAD);
    t_single(32'h8000_FFFC, 1'b0, 32'h0, 2'd2, 32'h0F0F_1E1E);
    t_idle_quiet();
    t_back_to_back();
    t_reset_mid_transfer();
    t_single(32'h0000_0004, 1'b0, 32'h0, 2'd1, 32'h7777_0001);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule